// File: doc/BRIEF.md
# Registered Shift Unit with Carry and Zero Flags

This block is the shift stage of an integer datapath. Each cycle it may take one 64-bit operand together with an operand-size select (32-bit or 64-bit), a shift amount and an operation code. The operation is a left shift, a logical right shift or an arithmetic right shift. One clock later it presents the shifted result, a carry flag and a zero flag, marked by an output valid pulse.

The shift amount is cut down to the range of the selected operand size before use. The carry flag keeps the last bit that left the operand. The zero flag reports an all-zero result. When the reduced amount is zero, the operand passes through unchanged and both flags keep their earlier values. This lets a chain of flag-dependent operations treat a zero-length shift as a no-op on the flags.

Top module: `shift_flag_unit`

## Requirements
- R1: The effective shift amount is `in_cnt[4:0]` when `in_wide` is 0 (32-bit mode, range 0..31) and `in_cnt[5:0]` when `in_wide` is 1 (64-bit mode, range 0..63). Higher bits of `in_cnt` are ignored.
- R2: Operation code 2'b00 is a left shift. Bits move toward the MSB and zeros enter at bit 0.
- R3: Operation code 2'b01 is a logical right shift. The vacated upper positions of the selected size are filled with zeros.
- R4: Operation code 2'b10 is an arithmetic right shift. The vacated upper positions are filled with the sign of the unshifted operand: bit 63 in 64-bit mode, bit 31 in 32-bit mode.
- R5: For a left shift by n ≥ 1 over a width of W bits, `out_carry` equals operand bit W−n, which is the last bit pushed out of the top.
- R6: For either right shift by n ≥ 1, `out_carry` equals operand bit n−1, which is the last bit pushed out of the bottom.
- R7: When the effective amount is zero, `out_res` equals the size-masked operand, and `out_carry` and `out_zero` keep their previous values.
- R8: In 32-bit mode only `in_opnd[31:0]` is used, and `out_res[63:32]` is zero.
- R9: `out_valid`, `out_res` and the flags are registered one clock after `in_valid`. `out_valid` is high for exactly one cycle per accepted input. A synchronous active-low reset clears `out_valid`, `out_res`, `out_carry` and `out_zero`.
- R10: For a nonzero effective amount, `out_zero` is 1 exactly when the size-masked result is all zeros.
- R11: Operation code 2'b11 behaves as a left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| in_op | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 left |
| in_cnt | input | 8 | Raw shift amount, masked per operand size |
| in_opnd | input | 64 | Operand to shift |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_res | output | 64 | Shifted result |
| out_carry | output | 1 | Last bit shifted out |
| out_zero | output | 1 | Result-is-zero flag |

## Verification
The assertions assume that `in_wide` and `in_op` are driven to known values in any cycle where `in_valid` is high. They also assume that reset is held low from time zero through at least one clock edge, so that the flag registers start from a defined value before any hold-on-zero-count property looks back at them.

The directed tasks raise `in_valid` for exactly one cycle per operation and drive every control input on the falling edge, which keeps them defined. Reset is applied for several cycles before the first request.

// File: rtl/shu_pkg.sv
// Package: shared widths, operation codes and helpers for the shift unit.
// Assumes the narrow operand size is exactly half the wide one.
package shu_pkg;

    parameter int DATA_W   = 64;
    parameter int HALF_W   = DATA_W / 2;
    parameter int CNT_W    = $clog2(DATA_W);
    parameter int CNT_IN_W = 8;

    typedef enum logic [1:0] {
        OP_LEFT  = 2'b00,
        OP_LSR   = 2'b01,
        OP_ASR   = 2'b10,
        OP_LEFT2 = 2'b11
    } shift_op_e;

    // Reverse bit order of a full-width word.
    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/shu_count_mask.sv
// Module: reduces the raw shift amount to the range of the operand size.
// Assumes: raw count is at least CNT_W bits wide; narrow size is DATA_W/2.
module shu_count_mask
    import shu_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int CIN_W = CNT_IN_W
) (
    input  logic               wide,
    input  logic [CIN_W-1:0]   cnt_raw,
    output logic [$clog2(DW)-1:0] cnt_eff,
    output logic               cnt_zero
);
    localparam int CW = $clog2(DW);

    // Keep all count bits for wide mode, drop the top one for narrow mode.
    always_comb begin
        cnt_eff = cnt_raw[CW-1:0];
        if (!wide) begin
            cnt_eff[CW-1] = 1'b0;
        end
        cnt_zero = (cnt_eff == '0);
    end

endmodule

// File: rtl/shu_core.sv
// Module: combinational shifter. A logarithmic right shifter serves all
// three operations; a left shift is done by reversing the data around it.
// Also selects the last bit shifted out. Assumes cnt_eff is already masked.
module shu_core
    import shu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic                  wide,
    input  logic [1:0]            op,
    input  logic [$clog2(DW)-1:0] cnt_eff,
    input  logic [DW-1:0]         opnd,
    output logic [DW-1:0]         res,
    output logic                  carry
);
    localparam int CW = $clog2(DW);
    localparam int HW = DW / 2;

    logic          is_left;
    logic          is_arith;
    logic          sign_bit;
    logic          fill_bit;
    logic [DW-1:0] ext;
    logic [DW-1:0] stage [CW+1];
    logic [CW:0]   size_w;
    logic [CW:0]   left_idx;
    logic [CW-1:0] right_idx;
    logic [DW-1:0] raw_out;

    // Decode the operation and pick the sign of the unshifted operand.
    always_comb begin
        is_left  = (op == OP_LEFT) || (op == OP_LEFT2);
        is_arith = (op == OP_ASR);
        sign_bit = wide ? opnd[DW-1] : opnd[HW-1];
        fill_bit = is_arith & sign_bit;
    end

    // Build the working operand: narrow mode extends bit HW-1 for arithmetic.
    always_comb begin
        if (wide) begin
            ext = opnd;
        end else begin
            ext = {{(DW-HW){fill_bit}}, opnd[HW-1:0]};
        end
        stage[0] = is_left ? bit_rev(ext) : ext;
    end

    // One stage per count bit, each shifting right by a power of two.
    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int SH = 1 << k;
        always_comb begin
            if (cnt_eff[k]) begin
                stage[k+1] = {{SH{fill_bit}}, stage[k][DW-1:SH]};
            end else begin
                stage[k+1] = stage[k];
            end
        end
    end

    // Undo the reversal for left shifts and clear the unused upper half.
    always_comb begin
        raw_out = is_left ? bit_rev(stage[CW]) : stage[CW];
        res     = raw_out;
        if (!wide) begin
            res[DW-1:HW] = '0;
        end
    end

    // Pick the last bit out: bit W-n for left, bit n-1 for right.
    always_comb begin
        size_w    = wide ? (CW+1)'(DW) : (CW+1)'(HW);
        left_idx  = size_w - {1'b0, cnt_eff};
        right_idx = cnt_eff - 1'b1;
        if (is_left) begin
            carry = ext[left_idx[CW-1:0]];
        end else begin
            carry = ext[right_idx];
        end
    end

endmodule

// File: rtl/shu_out_reg.sv
// Module: output register stage. Captures result and flags one cycle after
// a request; flags are held when the effective count is zero.
// Assumes: synchronous active-low reset held for at least one edge.
module shu_out_reg
    import shu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          wide,
    input  logic          cnt_zero,
    input  logic [DW-1:0] res_d,
    input  logic          carry_d,
    output logic          out_valid,
    output logic [DW-1:0] out_res,
    output logic          out_carry,
    output logic          out_zero
);
    localparam int HW = DW / 2;

    logic zero_d;

    // Zero detection on the already size-masked result.
    always_comb begin
        zero_d = (res_d == '0);
    end

    // Register the valid pulse and, on a request, result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_carry <= 1'b0;
            out_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res <= res_d;
                if (!cnt_zero) begin
                    out_carry <= carry_d;
                    out_zero  <= zero_d;
                end
            end
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_ZERO_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_zero) |=> ($stable(out_carry) && $stable(out_zero))); // R7
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(cnt_zero)) |-> (out_zero == (out_res == '0))); // R10
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(wide)) |-> (out_res[DW-1:HW] == '0)); // R8

endmodule

// File: rtl/shift_flag_unit.sv
// Module: top of the registered shift unit. Masks the count, shifts, and
// registers result, carry and zero flags with a one-cycle valid.
// Assumes: control inputs are known whenever in_valid is high.
module shift_flag_unit
    import shu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_wide,
    input  logic [1:0]          in_op,
    input  logic [CNT_IN_W-1:0] in_cnt,
    input  logic [DATA_W-1:0]   in_opnd,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_res,
    output logic                out_carry,
    output logic                out_zero
);
    logic [CNT_W-1:0]  cnt_eff;
    logic              cnt_zero;
    logic [DATA_W-1:0] res_d;
    logic              carry_d;

    shu_count_mask #(.DW(DATA_W), .CIN_W(CNT_IN_W)) i_mask (
        .wide     (in_wide),
        .cnt_raw  (in_cnt),
        .cnt_eff  (cnt_eff),
        .cnt_zero (cnt_zero)
    );

    shu_core #(.DW(DATA_W)) i_core (
        .wide    (in_wide),
        .op      (in_op),
        .cnt_eff (cnt_eff),
        .opnd    (in_opnd),
        .res     (res_d),
        .carry   (carry_d)
    );

    shu_out_reg #(.DW(DATA_W)) i_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .wide      (in_wide),
        .cnt_zero  (cnt_zero),
        .res_d     (res_d),
        .carry_d   (carry_d),
        .out_valid (out_valid),
        .out_res   (out_res),
        .out_carry (out_carry),
        .out_zero  (out_zero)
    );

endmodule

// File: tb/test_shift_flag_unit.sv
module test_shift_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_wide;
    logic [1:0]  in_op;
    logic [7:0]  in_cnt;
    logic [63:0] in_opnd;
    logic        out_valid;
    logic [63:0] out_res;
    logic        out_carry;
    logic        out_zero;

    int checks = 0;
    int errors = 0;
    logic m_carry;
    logic m_zero;

    always #2 clk = ~clk;

    shift_flag_unit i_shift_flag_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
        .in_op(in_op), .in_cnt(in_cnt), .in_opnd(in_opnd),
        .out_valid(out_valid), .out_res(out_res),
        .out_carry(out_carry), .out_zero(out_zero)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bit-serial reference: one step per count, updating model flags.
    task automatic model(input logic [1:0] op, input logic wide, input logic [7:0] cnt,
                         input logic [63:0] a, output logic [63:0] r);
        int w = wide ? 64 : 32;
        int n = wide ? int'(cnt[5:0]) : int'(cnt[4:0]);
        logic [63:0] v = wide ? a : {32'h0, a[31:0]};
        logic sgn = v[w-1];
        logic c = m_carry;
        for (int i = 0; i < n; i++) begin
            if (op == 2'b00 || op == 2'b11) begin
                c = v[w-1];
                v = v << 1;
            end else begin
                c = v[0];
                v = v >> 1;
                v[w-1] = (op == 2'b10) ? sgn : 1'b0;
            end
            if (!wide) v[63:32] = '0;
        end
        r = v;
        if (n != 0) begin
            m_carry = c;
            m_zero = (v == 64'h0);
        end
    endtask

    task automatic run_op(input string req, input logic [1:0] op, input logic wide,
                          input logic [7:0] cnt, input logic [63:0] a);
        logic [63:0] er;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_wide = wide; in_cnt = cnt; in_opnd = a;
        model(op, wide, cnt, a, er);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, {63'h0, out_valid}, 64'h1);
        chk({req, " result"}, out_res, er);
        chk({req, " carry"}, {63'h0, out_carry}, {63'h0, m_carry});
        chk({req, " zero"}, {63'h0, out_zero}, {63'h0, m_zero});
        @(negedge clk);
        chk("R9 valid pulse", {63'h0, out_valid}, 64'h0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_wide = 1'b1; in_op = 2'b00;
        in_cnt = '0; in_opnd = '0;
        repeat (4) @(negedge clk);
        chk("R9 reset valid", {63'h0, out_valid}, 64'h0);
        chk("R9 reset res", out_res, 64'h0);
        chk("R9 reset carry", {63'h0, out_carry}, 64'h0);
        chk("R9 reset zero", {63'h0, out_zero}, 64'h0);
        rst_n = 1'b1;
        m_carry = 1'b0; m_zero = 1'b0;
    endtask

    task automatic t_left;
        run_op("R2", 2'b00, 1'b1, 8'd4, 64'hF000_0000_0000_00A5);
        run_op("R5", 2'b00, 1'b1, 8'd1, 64'h8000_0000_0000_0000);
        chk("R5 left carry=1", {63'h0, out_carry}, 64'h1);
        run_op("R5", 2'b00, 1'b0, 8'd3, 64'h0000_0000_2000_0001);
        run_op("R2", 2'b00, 1'b1, 8'd63, 64'h0000_0000_0000_0003);
    endtask

    task automatic t_lsr;
        run_op("R3", 2'b01, 1'b1, 8'd8, 64'hFFFF_0000_1234_5678);
        run_op("R6", 2'b01, 1'b1, 8'd5, 64'h0000_0000_0000_0010);
        chk("R6 right carry=1", {63'h0, out_carry}, 64'h1);
        run_op("R3", 2'b01, 1'b0, 8'd31, 64'hFFFF_FFFF_8000_0000);
    endtask

    task automatic t_asr;
        run_op("R4", 2'b10, 1'b1, 8'd12, 64'h8000_0000_0000_0F00);
        run_op("R4", 2'b10, 1'b0, 8'd4, 64'h0000_0000_8765_4321);
        run_op("R4", 2'b10, 1'b0, 8'd4, 64'hFFFF_FFFF_7000_0000);
        run_op("R4", 2'b10, 1'b1, 8'd63, 64'h7FFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_mask;
        run_op("R1", 2'b00, 1'b0, 8'd33, 64'h0000_0000_0000_0001);
        chk("R1 narrow 33->1", out_res, 64'h2);
        run_op("R1", 2'b01, 1'b1, 8'hC2, 64'h0000_0000_0000_0100);
        chk("R1 wide 0xC2->2", out_res, 64'h40);
    endtask

    task automatic t_zero_cnt;
        run_op("R7", 2'b00, 1'b1, 8'd1, 64'h8000_0000_0000_0000);
        run_op("R7", 2'b01, 1'b1, 8'd64, 64'h0000_0000_0000_0002);
        chk("R7 pass", out_res, 64'h2);
        chk("R7 carry held", {63'h0, out_carry}, 64'h1);
        chk("R7 zero held", {63'h0, out_zero}, 64'h1);
        run_op("R7", 2'b10, 1'b0, 8'd32, 64'hAAAA_BBBB_CCCC_DDDD);
        chk("R7 narrow pass", out_res, 64'h0000_0000_CCCC_DDDD);
    endtask

    task automatic t_narrow;
        run_op("R8", 2'b00, 1'b0, 8'd8, 64'hFFFF_FFFF_FF00_0001);
        chk("R8 upper zero", out_res[63:32], 64'h0);
        run_op("R10", 2'b01, 1'b0, 8'd16, 64'hFFFF_FFFF_0000_8000);
        chk("R10 zero set", {63'h0, out_zero}, 64'h1);
    endtask

    task automatic t_op3;
        run_op("R11", 2'b11, 1'b1, 8'd7, 64'h0123_4567_89AB_CDEF);
        run_op("R11", 2'b11, 1'b0, 8'd20, 64'h0000_0000_0001_F000);
    endtask

    task automatic t_sweep;
        logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 60; i++) begin
            s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
            run_op("R10 sweep", s[1:0], s[9], s[23:16], {s[31:0], s[63:32]} ^ s);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_left();
        t_lsr();
        t_asr();
        t_mask();
        t_zero_cnt();
        t_narrow();
        t_op3();
        t_sweep();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule